// File: doc/BRIEF.md
# Floating-Point Status and Exception Update Unit

This block owns the floating-point status word of a processor core and updates it each time an arithmetic unit completes an operation. The arithmetic unit pulses a completion strobe for one cycle together with five raw exception indications. The block compares them with the enable bits held in the status word. Exceptions that are not enabled accumulate into sticky flag bits. Exceptions that are enabled raise the trap bit, produce a one-cycle trap request and fill a 32-bit exception word that the trap handler reads.

Software can overwrite the whole status word at any time through a write strobe, and that write wins over an operation completing in the same cycle. The block also decodes the rounding-mode field into a one-hot selection and drives a flush-to-zero enable back to the arithmetic datapath. When that enable is set, the datapath flushes denormal inputs and outputs to zero, and it makes that decision before rounding. All control and status pins are plain level or strobe signals. There is no streaming interface and no back-pressure: the completion strobe is accepted in every cycle.

Top module: `fsu_status_unit`

Status word layout:
- enable bits 4:0 (bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact)
- flush enable at bit 5
- trap bit at bit 6
- rounding mode at bits 10:9
- sticky flags at bits 31:27 (flag of exception i at bit 27+i)

The exception-input vector uses the same bit order as the enables.

## Requirements
- R1: Reset clears the status word, the exception word and the trap request, so rounding is nearest-even, flushing is off and every exception is disabled.
- R2: The rounding field (status bits 10:9) decodes to a one-hot output, where value 0 gives bit 0 (nearest-even), 1 gives bit 1 (toward zero), 2 gives bit 2 (toward +infinity) and 3 gives bit 3 (toward -infinity).
- R3: The flush-to-zero output equals status bit 5.
- R4: A completion whose exception vector is zero leaves the status word unchanged and sets the exception word to zero.
- R5: Each raised exception whose enable bit is clear sets its sticky flag at status bit 27+i. Sticky flags are cleared only by reset or a software write.
- R6: When any raised exception has its enable bit set, status bit 6 becomes 1 on the same clock edge, and the trap request is high for exactly the one cycle that follows.
- R7: On a trap where overflow or underflow is among the enabled raised exceptions, the exception word becomes exactly bit 26 plus bit 29 (value 0x24000000).
- R8: On any other trap, the exception word holds the enabled raised exceptions at bits 27+i and zeros elsewhere.
- R9: A software write in the same cycle as a completion loads the written value, and the completion is dropped: no trap request and no change to the exception word.
- R10: A completion with exceptions but none enabled sets the exception word to zero. Between completions the exception word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe for the status word |
| sw_data | input | 32 | Value written to the status word |
| op_done | input | 1 | One-cycle operation-completion strobe |
| op_exc | input | 5 | Raw exceptions: bit 0 invalid, 1 divide-by-zero, 2 overflow, 3 underflow, 4 inexact |
| status_o | output | 32 | Current status word |
| excword_o | output | 32 | Exception word for the trap handler |
| trap_req_o | output | 1 | Registered one-cycle trap request |
| rnd_mode_o | output | 4 | One-hot rounding mode |
| ftz_en_o | output | 1 | Flush-denormals-to-zero enable |

## Verification
Every piece of internal state is visible at the ports one cycle after it changes, because the status word, the exception word and the trap request are all registered outputs. A wrong enable-to-flag mapping, a lost sticky bit or a misplaced trap bit therefore shows up on the first completion after the faulty state forms. A trap request that stays high, or that fires without an enabled exception, shows up in the cycle right after the edge that registered it. Errors in the rounding and flush decoding are combinational and appear in the same cycle as the status value that causes them.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  localparam int STAT_W   = 32;
  localparam int NEXC     = 5;
  localparam int EN_LSB   = 0;
  localparam int FLAG_LSB = 27;
  localparam int D_BIT    = 5;
  localparam int T_BIT    = 6;
  localparam int RM_LSB   = 9;
  localparam int RM_W     = 2;
  localparam int NMODES   = 1 << RM_W;
  localparam int C_BIT    = 26;

  typedef enum int {
    EX_INVALID  = 0,
    EX_DIVZERO  = 1,
    EX_OVERFLOW = 2,
    EX_UNDERFLW = 3,
    EX_INEXACT  = 4
  } exc_idx_e;

  typedef enum logic [RM_W-1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_POSINF  = 2'd2,
    RND_NEGINF  = 2'd3
  } rnd_e;
endpackage

// File: rtl/fsu_exc_eval.sv
module fsu_exc_eval
  import fsu_pkg::*;
(
  input  logic [NEXC-1:0]   enables_i,
  input  logic [NEXC-1:0]   exc_i,
  output logic              trap_hit_o,
  output logic [STAT_W-1:0] xword_o,
  output logic [STAT_W-1:0] sticky_o
);
  logic [NEXC-1:0] hit;
  logic [NEXC-1:0] miss;
  logic            collapse;

  assign hit        = exc_i & enables_i;
  assign miss       = exc_i & ~enables_i;
  assign trap_hit_o = |hit;
  assign collapse   = hit[EX_OVERFLOW] | hit[EX_UNDERFLW];

  // Exceptions map onto flag positions one to one.
  genvar g;
  generate
    for (g = 0; g < STAT_W; g++) begin : g_map
      if (g >= FLAG_LSB && g < FLAG_LSB + NEXC) begin : g_flag
        assign sticky_o[g] = miss[g-FLAG_LSB];
      end else begin : g_zero
        assign sticky_o[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    xword_o = '0;
    if (trap_hit_o) begin
      if (collapse) begin
        xword_o[C_BIT]                = 1'b1;
        xword_o[FLAG_LSB+EX_OVERFLOW] = 1'b1;
      end else begin
        xword_o[FLAG_LSB +: NEXC] = hit;
      end
    end
  end
endmodule

// File: rtl/fsu_mode_decode.sv
module fsu_mode_decode
  import fsu_pkg::*;
(
  input  logic [RM_W-1:0]   rm_field_i,
  input  logic              flush_bit_i,
  output logic [NMODES-1:0] rnd_onehot_o,
  output logic              ftz_en_o
);
  genvar m;
  generate
    for (m = 0; m < NMODES; m++) begin : g_mode
      assign rnd_onehot_o[m] = (rm_field_i == RM_W'(m));
    end
  endgenerate

  assign ftz_en_o = flush_bit_i;
endmodule

// File: rtl/fsu_status_reg.sv
module fsu_status_reg
  import fsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_data,
  input  logic              op_done,
  input  logic              trap_hit_i,
  input  logic [STAT_W-1:0] xword_i,
  input  logic [STAT_W-1:0] sticky_i,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] xword_q,
  output logic              trap_q
);
  logic [STAT_W-1:0] status_d;
  logic [STAT_W-1:0] xword_d;
  logic              trap_d;

  always_comb begin
    status_d = status_q;
    xword_d  = xword_q;
    trap_d   = 1'b0;
    if (sw_we) begin
      status_d = sw_data;
    end else if (op_done) begin
      status_d = status_q | sticky_i;
      if (trap_hit_i) status_d[T_BIT] = 1'b1;
      xword_d = xword_i;
      trap_d  = trap_hit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      xword_q  <= '0;
      trap_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      xword_q  <= xword_d;
      trap_q   <= trap_d;
    end
  end
endmodule

// File: rtl/fsu_status_unit.sv
module fsu_status_unit
  import fsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [STAT_W-1:0] sw_data,
  input  logic              op_done,
  input  logic [NEXC-1:0]   op_exc,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] excword_o,
  output logic              trap_req_o,
  output logic [NMODES-1:0] rnd_mode_o,
  output logic              ftz_en_o
);
  logic              trap_hit;
  logic [STAT_W-1:0] xword_nxt;
  logic [STAT_W-1:0] sticky;

  fsu_exc_eval u_eval (
    .enables_i (status_o[EN_LSB +: NEXC]),
    .exc_i     (op_exc),
    .trap_hit_o(trap_hit),
    .xword_o   (xword_nxt),
    .sticky_o  (sticky)
  );

  fsu_status_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (sw_we),
    .sw_data   (sw_data),
    .op_done   (op_done),
    .trap_hit_i(trap_hit),
    .xword_i   (xword_nxt),
    .sticky_i  (sticky),
    .status_q  (status_o),
    .xword_q   (excword_o),
    .trap_q    (trap_req_o)
  );

  fsu_mode_decode u_mode (
    .rm_field_i  (status_o[RM_LSB +: RM_W]),
    .flush_bit_i (status_o[D_BIT]),
    .rnd_onehot_o(rnd_mode_o),
    .ftz_en_o    (ftz_en_o)
  );
endmodule

// File: rtl/fsu_status_chk.sv
module fsu_status_chk
  import fsu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sw_we,
  input logic [STAT_W-1:0] sw_data,
  input logic              op_done,
  input logic [NEXC-1:0]   op_exc,
  input logic [STAT_W-1:0] status_o,
  input logic [STAT_W-1:0] excword_o,
  input logic              trap_req_o,
  input logic [NMODES-1:0] rnd_mode_o
);
  // R2
  rnd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rnd_mode_o) == 1);

  // R6
  trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> $past(op_done && !sw_we && |(op_exc & status_o[EN_LSB +: NEXC])));

  // R6
  trap_tbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req_o |-> status_o[T_BIT]);

  // R4
  no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !sw_we && op_exc == '0) |=> (excword_o == '0 && status_o == $past(status_o)));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((status_o[FLAG_LSB +: NEXC] & $past(status_o[FLAG_LSB +: NEXC]))
                == $past(status_o[FLAG_LSB +: NEXC])));

  // R9
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> (status_o == $past(sw_data) && !trap_req_o));

  // R10
  xword_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_done |=> $stable(excword_o));
endmodule

bind fsu_status_unit fsu_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_we     (sw_we),
  .sw_data   (sw_data),
  .op_done   (op_done),
  .op_exc    (op_exc),
  .status_o  (status_o),
  .excword_o (excword_o),
  .trap_req_o(trap_req_o),
  .rnd_mode_o(rnd_mode_o)
);

// File: tb/tb_fsu_status_unit.sv
`timescale 1ns/1ps
module tb_fsu_status_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_we;
  logic [31:0] sw_data;
  logic        op_done;
  logic [4:0]  op_exc;
  logic [31:0] status_o;
  logic [31:0] excword_o;
  logic        trap_req_o;
  logic [3:0]  rnd_mode_o;
  logic        ftz_en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fsu_status_unit dut (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_data(sw_data),
    .op_done(op_done), .op_exc(op_exc), .status_o(status_o),
    .excword_o(excword_o), .trap_req_o(trap_req_o),
    .rnd_mode_o(rnd_mode_o), .ftz_en_o(ftz_en_o)
  );

  localparam int NV = 9;
  // preset status, exceptions, expected status, exception word, trap
  localparam logic [31:0] V_PRE [NV] = '{
    32'h0000_0000, 32'h0000_0010, 32'h0000_0004, 32'h0000_0008, 32'h0000_0001,
    32'h0000_0003, 32'h0000_001F, 32'h2000_0620, 32'h0000_001C};
  localparam logic [4:0] V_EXC [NV] = '{
    5'b10000, 5'b10000, 5'b10100, 5'b11000, 5'b00010,
    5'b00011, 5'b00000, 5'b00110, 5'b10100};
  localparam logic [31:0] V_STAT [NV] = '{
    32'h8000_0000, 32'h0000_0050, 32'h8000_0044, 32'h8000_0048, 32'h1000_0001,
    32'h0000_0043, 32'h0000_001F, 32'h3000_0620, 32'h0000_005C};
  localparam logic [31:0] V_XW [NV] = '{
    32'h0000_0000, 32'h8000_0000, 32'h2400_0000, 32'h2400_0000, 32'h0000_0000,
    32'h1800_0000, 32'h0000_0000, 32'h0000_0000, 32'h2400_0000};
  localparam logic V_TRAP [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [31:0] v);
    @(negedge clk);
    sw_we = 1'b1; sw_data = v;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sw_we = 1'b0; sw_data = '0; op_done = 1'b0; op_exc = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status_o, 32'h0);
    chk("R1 excword", excword_o, 32'h0);
    chk("R1 trap", {31'd0, trap_req_o}, 32'h0);
    chk("R1 rnd", {28'd0, rnd_mode_o}, 32'h1);
    chk("R1 ftz", {31'd0, ftz_en_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector walk: R4 R5 R6 R7 R8 R10
    for (int k = 0; k < NV; k++) begin
      sw_write(V_PRE[k]);
      op_done = 1'b1; op_exc = V_EXC[k];
      @(negedge clk);
      op_done = 1'b0; op_exc = '0;
      chk($sformatf("R5/R6 status vec%0d", k), status_o, V_STAT[k]);
      chk($sformatf("R7/R8/R10 excword vec%0d", k), excword_o, V_XW[k]);
      chk($sformatf("R6 trap vec%0d", k), {31'd0, trap_req_o}, {31'd0, V_TRAP[k]});
      @(negedge clk);
      chk($sformatf("R6 trap pulse end vec%0d", k), {31'd0, trap_req_o}, 32'h0);
      chk($sformatf("R4 status held vec%0d", k), status_o, V_STAT[k]);
    end

    // R2 and R3: rounding decode and flush bit
    for (int m = 0; m < 4; m++) begin
      sw_write((32'(m) << 9) | (32'(m & 1) << 5));
      chk($sformatf("R2 rnd mode %0d", m), {28'd0, rnd_mode_o}, 32'h1 << m);
      chk($sformatf("R3 ftz mode %0d", m), {31'd0, ftz_en_o}, 32'(m & 1));
    end

    // R10: exception word holds across idle cycles
    sw_write(32'h0000_0010);
    op_done = 1'b1; op_exc = 5'b10000;
    @(negedge clk);
    op_done = 1'b0; op_exc = '0;
    repeat (3) @(negedge clk);
    chk("R10 excword held", excword_o, 32'h8000_0000);

    // R9: software write wins over a same-cycle completion
    @(negedge clk);
    sw_we = 1'b1; sw_data = 32'h0000_0004; op_done = 1'b1; op_exc = 5'b00100;
    @(negedge clk);
    sw_we = 1'b0; op_done = 1'b0; op_exc = '0;
    chk("R9 status", status_o, 32'h0000_0004);
    chk("R9 trap", {31'd0, trap_req_o}, 32'h0);
    chk("R9 excword", excword_o, 32'h8000_0000);

    // R5: sticky flags survive later completions
    sw_write(32'h0);
    op_done = 1'b1; op_exc = 5'b00001;
    @(negedge clk);
    op_exc = 5'b01000;
    @(negedge clk);
    op_done = 1'b0; op_exc = '0;
    chk("R5 accumulate", status_o, 32'h4800_0000);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 status after reset", status_o, 32'h0);
    chk("R1 excword after reset", excword_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule